// File: doc/BRIEF.md
# PPS-Synchronised Timekeeper

This block keeps a 64-bit time value: a 32-bit seconds count and a 32-bit sub-second tick count. The tick count advances once per clock. When the tick count reaches a programmable ticks-per-second limit, it returns to zero and the seconds count steps up by one. Software sets a new time by writing staged seconds and ticks values over a simple address/data strobe. The staged value is applied in one of two ways: at once, or on the next active edge of a pulse-per-second (PPS) reference.

Two PPS inputs are available, and a flag picks which one is used. A second flag picks whether the rising or the falling edge of the selected input is active. Each PPS input passes through a flop synchroniser before edge detection. On every active edge the block records the running time, so software can read both the live time and the time at the most recent PPS.

The settings strobe is a control path with no back-pressure. A write is taken in every cycle in which the strobe is high, and there is no ready signal. Writes to addresses outside the map are ignored.

Top module: `pps_timekeeper`

## Requirements
- R1: Reset state.
  - The live time, the PPS snapshot and the staged time are all zero.
  - The edge flag selects the falling edge and the source flag selects input A.
  - Load-at-PPS mode is selected and no load is pending.
  - The tick limit is the parameter `TPS_DEFAULT`.
- R2: Counting.
  - In each cycle without a load, the ticks value increments by one.
  - When ticks equal the tick limit minus one, ticks become 0 and the seconds value increments, wrapping modulo 2^32.
- R3: Immediate load.
  - When the immediate-mode bit is 1, a write to the ticks address arms a load.
  - The staged seconds and ticks appear on the time outputs one clock edge after the write is registered.
- R4: PPS load.
  - When the immediate-mode bit is 0, an armed load is applied on the active PPS edge.
  - The time outputs show the staged value after the third rising clock edge that follows the change on the PPS input.
- R5: Edge selection.
  - Flags bit 0 selects the active edge: 0 means the falling edge and 1 means the rising edge.
  - The other edge neither loads the time nor updates the snapshot.
- R6: Source selection.
  - Flags bit 1 selects the PPS input: 0 means input A and 1 means input B.
  - Edges on the unselected input have no effect.
- R7: Single-shot load.
  - An armed load is applied once and is then disarmed.
  - A later active edge with no new arming write leaves the running time untouched.
- R8: PPS snapshot.
  - Every active PPS edge copies the time value held just before that clock edge into the snapshot outputs.
  - This happens whether or not a load is pending.
- R9: Settings map (word addresses on `set_addr`). All writes take effect at the clock edge on which `set_stb` is high.

  | Address | Content |
  |---------|---------|
  | 0 | Staged seconds |
  | 1 | Staged ticks (the write also arms a load) |
  | 2 | Flags (bit 0 is the edge flag, bit 1 is the source flag) |
  | 3 | Immediate-mode bit in data bit 0 (the write also arms a load) |
  | 4 | Tick limit |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; ticks advance once per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | ADDR_W | Settings word address |
| set_data | input | 32 | Settings write data |
| pps_a | input | 1 | PPS input A, asynchronous |
| pps_b | input | 1 | PPS input B, asynchronous |
| time_secs | output | 32 | Live seconds |
| time_ticks | output | 32 | Live ticks |
| last_pps_secs | output | 32 | Seconds captured at the last active PPS edge |
| last_pps_ticks | output | 32 | Ticks captured at the last active PPS edge |

## Verification
The bench builds the block with `TPS_DEFAULT` set to 16. This makes a seconds rollover after reset visible within twenty cycles. The vector table reprograms the tick limit as low as 1 and 4. This brings wrap-at-limit, seconds overflow past 2^32-1 and a seconds step on every cycle within a few clocks. The directed PPS tests use a limit of 1000, so the predicted tick counts after each edge stay unwrapped and can be compared exactly.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int TK_W = 32;

  typedef struct packed {
    logic [TK_W-1:0] secs;
    logic [TK_W-1:0] ticks;
  } tk_time_t;

  typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } tk_edge_e;
  typedef enum logic { SRC_A = 1'b0, SRC_B = 1'b1 } tk_src_e;
endpackage

// File: rtl/tk_settings.sv
module tk_settings
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [TK_W-1:0] TPS_DEFAULT = 32'd100,
  parameter logic [ADDR_W-1:0] A_SECS  = 0,
  parameter logic [ADDR_W-1:0] A_TICKS = 1,
  parameter logic [ADDR_W-1:0] A_FLAGS = 2,
  parameter logic [ADDR_W-1:0] A_IMM   = 3,
  parameter logic [ADDR_W-1:0] A_TPS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TK_W-1:0]   data,
  input  logic              load_taken,
  output tk_time_t          staged,
  output tk_edge_e          edge_sel,
  output tk_src_e           src_sel,
  output logic              imm_mode,
  output logic [TK_W-1:0]   tps,
  output logic              armed
);
  logic arm_set;
  assign arm_set = stb && (addr == A_TICKS || addr == A_IMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      staged   <= '0;
      edge_sel <= EDGE_FALL;
      src_sel  <= SRC_A;
      imm_mode <= 1'b0;
      tps      <= TPS_DEFAULT;
      armed    <= 1'b0;
    end else begin
      if (stb) begin
        if (addr == A_SECS)  staged.secs  <= data;
        if (addr == A_TICKS) staged.ticks <= data;
        if (addr == A_FLAGS) begin
          edge_sel <= tk_edge_e'(data[0]);
          src_sel  <= tk_src_e'(data[1]);
        end
        if (addr == A_IMM)   imm_mode <= data[0];
        if (addr == A_TPS)   tps      <= data;
      end
      armed <= arm_set | (armed & ~load_taken);
    end
  end

  // R7: a consumed load with no fresh arming leaves the block disarmed
  a_r7_single_shot: assert property (@(posedge clk) disable iff (rst)
    (armed && load_taken && !arm_set) |=> !armed);
endmodule

// File: rtl/tk_pps_detect.sv
module tk_pps_detect
  import tk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pps_a,
  input  logic     pps_b,
  input  tk_edge_e edge_sel,
  input  tk_src_e  src_sel,
  output logic     pps_evt
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0] raw;
  logic [N_SRC-1:0] synced;
  logic             sel_q, prev_q, rise, fall;

  assign raw = {pps_b, pps_a};

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[SYNC_STAGES-1];
  end

  assign sel_q = (src_sel == SRC_B) ? synced[1] : synced[0];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_q;
  end

  assign rise    = sel_q & ~prev_q;
  assign fall    = ~sel_q & prev_q;
  assign pps_evt = (edge_sel == EDGE_RISE) ? rise : fall;

  // R5: with steady selections, two events of one polarity cannot be adjacent
  a_r5_no_double_event: assert property (@(posedge clk) disable iff (rst)
    pps_evt |=> (!pps_evt || edge_sel != $past(edge_sel) || src_sel != $past(src_sel)));
endmodule

// File: rtl/tk_counter.sv
module tk_counter
  import tk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  tk_time_t        load_val,
  input  logic [TK_W-1:0] tps,
  input  logic            pps_evt,
  output tk_time_t        now,
  output tk_time_t        snap
);
  logic at_limit;
  assign at_limit = (now.ticks == tps - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      now  <= '0;
      snap <= '0;
    end else begin
      if (load) begin
        now <= load_val;
      end else if (at_limit) begin
        now.ticks <= '0;
        now.secs  <= now.secs + 1'b1;
      end else begin
        now.ticks <= now.ticks + 1'b1;
      end
      if (pps_evt) snap <= now;
    end
  end

  // R3 / R4: a load puts the staged value on the outputs
  a_r3_load_applied: assert property (@(posedge clk) disable iff (rst)
    load |=> (now == $past(load_val)));
  // R2: roll-over at the limit
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && at_limit) |=> (now.ticks == '0 && now.secs == $past(now.secs) + 1'b1));
  // R2: ordinary tick
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!load && !at_limit) |=> (now.ticks == $past(now.ticks) + 1'b1 && $stable(now.secs)));
  // R8: snapshot holds the pre-edge time
  a_r8_snapshot: assert property (@(posedge clk) disable iff (rst)
    pps_evt |=> (snap == $past(now)));
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] TPS_DEFAULT = 32'd100_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [31:0]       set_data,
  input  logic              pps_a,
  input  logic              pps_b,
  output logic [31:0]       time_secs,
  output logic [31:0]       time_ticks,
  output logic [31:0]       last_pps_secs,
  output logic [31:0]       last_pps_ticks
);
  tk_time_t        staged, now, snap;
  tk_edge_e        edge_sel;
  tk_src_e         src_sel;
  logic            imm_mode, armed, pps_evt, load;
  logic [TK_W-1:0] tps;

  assign load = armed & (imm_mode | pps_evt);

  tk_settings #(
    .ADDR_W(ADDR_W), .TPS_DEFAULT(TPS_DEFAULT),
    .A_SECS(ADDR_W'(0)), .A_TICKS(ADDR_W'(1)), .A_FLAGS(ADDR_W'(2)),
    .A_IMM(ADDR_W'(3)), .A_TPS(ADDR_W'(4))
  ) u_settings (
    .clk(clk), .rst(rst), .stb(set_stb), .addr(set_addr), .data(set_data),
    .load_taken(load), .staged(staged), .edge_sel(edge_sel), .src_sel(src_sel),
    .imm_mode(imm_mode), .tps(tps), .armed(armed)
  );

  tk_pps_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk(clk), .rst(rst), .pps_a(pps_a), .pps_b(pps_b),
    .edge_sel(edge_sel), .src_sel(src_sel), .pps_evt(pps_evt)
  );

  tk_counter u_count (
    .clk(clk), .rst(rst), .load(load), .load_val(staged), .tps(tps),
    .pps_evt(pps_evt), .now(now), .snap(snap)
  );

  assign time_secs      = now.secs;
  assign time_ticks     = now.ticks;
  assign last_pps_secs  = snap.secs;
  assign last_pps_ticks = snap.ticks;

  // R4: without a pending load, a PPS edge leaves the live time counting normally
  a_r4_no_load_unarmed: assert property (@(posedge clk) disable iff (rst)
    (!armed && !(set_stb && set_addr == ADDR_W'(4))) |=>
      (time_ticks == $past(time_ticks) + 1'b1 || time_ticks == '0));
endmodule

// File: tb/pps_timekeeper_tb.sv
module pps_timekeeper_tb;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_SECS = 0, A_TICKS = 1, A_FLAGS = 2, A_IMM = 3, A_TPS = 4;

  logic clk = 1'b0, rst = 1'b1, set_stb = 1'b0, pps_a = 1'b0, pps_b = 1'b0;
  logic [AW-1:0] set_addr = '0;
  logic [31:0] set_data = '0;
  logic [31:0] time_secs, time_ticks, last_pps_secs, last_pps_ticks;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pps_timekeeper #(.ADDR_W(AW), .TPS_DEFAULT(32'd16)) u_dut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .pps_a(pps_a), .pps_b(pps_b), .time_secs(time_secs), .time_ticks(time_ticks),
    .last_pps_secs(last_pps_secs), .last_pps_ticks(last_pps_ticks)
  );

  // {secs, ticks, tps, extra edges, expected secs, expected ticks}
  localparam logic [191:0] VEC [8] = '{
    {32'd10,         32'd0,  32'd100, 32'd5,  32'd10,  32'd5},
    {32'd7,          32'd98, 32'd100, 32'd1,  32'd7,   32'd99},
    {32'd7,          32'd99, 32'd100, 32'd1,  32'd8,   32'd0},
    {32'hFFFF_FFFF,  32'd3,  32'd4,   32'd1,  32'd0,   32'd0},
    {32'd20,         32'd0,  32'd1,   32'd3,  32'd23,  32'd0},
    {32'd5,          32'd2,  32'd10,  32'd25, 32'd7,   32'd7},
    {32'd100,        32'd0,  32'd3,   32'd7,  32'd102, 32'd1},
    {32'd0,          32'h10, 32'h20,  32'h10, 32'd1,   32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    set_stb = 1'b1; set_addr = a; set_data = d;
    @(negedge clk);
    set_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 secs", time_secs, 32'd0);
    chk("R1 ticks", time_ticks, 32'd0);
    chk("R1 snap secs", last_pps_secs, 32'd0);
    chk("R1 snap ticks", last_pps_ticks, 32'd0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R1 R2 default limit secs", time_secs, 32'd1);
    chk("R1 R2 default limit ticks", time_ticks, 32'd4);

    wr(A_IMM, 32'd1);
    for (int i = 0; i < 8; i++) begin
      logic [191:0] v;
      v = VEC[i];
      wr(A_TPS, v[127:96]);
      wr(A_SECS, v[191:160]);
      wr(A_TICKS, v[159:128]);
      @(posedge clk);
      repeat (int'(v[95:64])) @(posedge clk);
      @(negedge clk);
      chk("R2 R3 R9 vector secs", time_secs, v[63:32]);
      chk("R2 R3 R9 vector ticks", time_ticks, v[31:0]);
    end

    // PPS load on falling edge of input A
    wr(A_TPS, 32'd1000);
    wr(A_SECS, 32'd50);
    wr(A_TICKS, 32'd0);
    wr(A_IMM, 32'd0);
    wr(A_SECS, 32'd200);
    wr(A_TICKS, 32'd500);
    pps_a = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 rising ignored secs", time_secs, 32'd50);
    chk("R5 rising ignored snap", last_pps_secs, 32'd0);
    pps_a = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 pps load ticks", time_ticks, 32'd500);
    chk("R4 pps load secs", time_secs, 32'd200);
    chk("R8 snap before load", last_pps_secs, 32'd50);
    pps_a = 1'b1;
    repeat (4) @(negedge clk);
    pps_a = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 no reload ticks", time_ticks, 32'd507);
    chk("R7 no reload secs", time_secs, 32'd200);
    chk("R8 snap unarmed ticks", last_pps_ticks, 32'd506);
    chk("R8 snap unarmed secs", last_pps_secs, 32'd200);

    // Rising edge on input B
    wr(A_FLAGS, 32'd3);
    wr(A_SECS, 32'd900);
    wr(A_TICKS, 32'd7);
    pps_a = 1'b1;
    repeat (4) @(negedge clk);
    pps_a = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 other source ignored", time_secs, 32'd200);
    pps_b = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 source B load ticks", time_ticks, 32'd7);
    chk("R5 R6 rising load secs", time_secs, 32'd900);
    chk("R8 snap on B", last_pps_secs, 32'd200);
    pps_b = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 falling ignored snap", last_pps_secs, 32'd200);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule